// File: doc/BRIEF.md
# Serial Peripheral Master with Separate Write and Read Clocking

This block is a single-target SPI master. It drives the serial clock, an active-low chip select and the outbound data line, and it samples the inbound data line. Each transfer moves one word of `WORD_W` bits in both directions, most significant bit first. The host starts a transfer with a start/busy/done handshake. It supplies a transmit word and a flag that marks the transfer as a read or a write. When the transfer ends, it collects the received word.

Some peripherals latch incoming bits and change outgoing bits on the same clock edge. Such a part needs a different clock arrangement for writes than for reads. The master therefore holds two 2-bit scheme selects, one for write transfers and one for read transfers. It picks the matching one when each transfer starts, so the host never reprograms the clocking between a configuration write and a data read.

The serial clock is derived from the system clock by a programmable half-period count. Chip select leads the first serial edge by one half-period and trails the last one by one half-period.

Top module: `spi_dualscheme_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 1 (idle high), busy is 0, done is 0 and rx_word is 0.
- R2: A start sampled while busy is 0 begins a transfer: busy and the chip select (cs_n low) both take effect at that same clock edge. A start sampled while busy is 1 is ignored, and its transmit word never reaches mosi.
- R3: A transfer with rw_read=0 uses wr_scheme and one with rw_read=1 uses rd_scheme. The scheme, tx_word and half_div are captured at the accepting edge, and later changes to these inputs have no effect on a running transfer.
- R4: Scheme encoding: bit 1 is the idle level of sclk (1 = idle high, so the first edge of the word is falling), and bit 0 selects early launch. The edge leaving the idle level is the leading edge and the one returning to it is the trailing edge. Code 2'b10 is the falling-edge scheme without delay and 2'b11 is the falling-edge scheme with delay.
- R5: With bit 0 clear, each data bit is driven on mosi at a leading edge and miso is sampled at the following trailing edge. Before the first edge, mosi is 0.
- R6: With bit 0 set, the first bit is on mosi from the accepting edge, miso is sampled at each leading edge, and the next bit is driven at each trailing edge. After the final trailing edge, mosi is 0.
- R7: Every sclk half-period lasts half_div+1 system clocks. From the accepting edge to the edge that raises done there are (2*WORD_W+1)*(half_div+1) clocks.
- R8: cs_n falls at the accepting edge. The first sclk edge comes one half-period later, and cs_n rises one half-period after the last (2*WORD_W-th) sclk edge, with sclk unchanged at that moment.
- R9: Bits go out and come in most significant bit first. rx_word takes the sampled word at the edge where done rises and holds it until the next completion.
- R10: done is high for exactly one clock, in the cycle where busy has just fallen. A start held in that cycle is accepted at the next edge.
- R11: While idle, sclk holds the idle level of the last transfer's scheme. At an accepting edge it moves to the idle level of the new scheme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer |
| rw_read | input | 1 | 1 = read transfer (rd_scheme), 0 = write transfer (wr_scheme) |
| tx_word | input | WORD_W | Word shifted out on mosi |
| wr_scheme | input | 2 | Clocking scheme for write transfers |
| rd_scheme | input | 2 | Clocking scheme for read transfers |
| half_div | input | DIV_W | sclk half-period length minus one, in system clocks |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rx_word | output | WORD_W | Last received word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the peripheral |

## Verification
The bench alternates write and read transfers that use different schemes. This exposes a master that applies one global mode: the peripheral model would then receive or return the word shifted by a bit. All four codes are run both as the write scheme and as the read scheme. A design that swaps the launch and capture edges, or forgets the early first bit, shows a mismatch on mosi in the per-clock comparison or a wrong rx_word. Several transfers are run with half_div set to zero, so a divider that stretches or drops a half-period is caught by the clock count to done.

Other cases target control and latching. A second start, a changed scheme and a changed divider are applied in the middle of a transfer, which catches a design that re-reads its inputs. A start held through the done cycle checks that back-to-back words are neither lost nor accepted one cycle early. An idle-low write placed between idle-high transfers checks the level that sclk rests at.

// File: rtl/spi_ds_pkg.sv
package spi_ds_pkg;

   // Clocking scheme: idle level of the serial clock, and early launch
   typedef struct packed {
      logic idle_hi;
      logic early;
   } scheme_t;

   function automatic scheme_t pick_scheme(input logic is_read,
                                           input logic [1:0] wr_code,
                                           input logic [1:0] rd_code);
      logic [1:0] code;
      code = is_read ? rd_code : wr_code;
      return scheme_t'(code);
   endfunction

endpackage

// File: rtl/spi_ds_halfgen.sv
module spi_ds_halfgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] div_in,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= '0;
      end else if (load) begin
         div_q <= div_in;
         cnt_q <= '0;
      end else if (run) begin
         if (cnt_q == div_q) cnt_q <= '0;
         else                cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

   assign tick = run && !load && (cnt_q == div_q);

endmodule

// File: rtl/spi_ds_seq.sv
module spi_ds_seq
   import spi_ds_pkg::*;
#(
   parameter int   WORD_W        = 16,
   parameter logic RESET_IDLE_HI = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    go,
   input  scheme_t scheme_in,
   input  logic    tick,
   output logic    busy,
   output logic    done,
   output logic    cs_n,
   output logic    sclk,
   output logic    early_q,
   output logic    lead_evt,
   output logic    trail_evt,
   output logic    fin_evt
);

   localparam int            HALF_N = 2 * WORD_W;
   localparam int            HW     = $clog2(HALF_N + 1);
   localparam logic [HW-1:0] LAST_H = HW'(HALF_N);

   logic [HW-1:0] h_q;
   logic          edge_ok;

   assign edge_ok   = busy && tick && (h_q != LAST_H);
   assign lead_evt  = edge_ok && !h_q[0];
   assign trail_evt = edge_ok &&  h_q[0];
   assign fin_evt   = busy && tick && (h_q == LAST_H);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         cs_n    <= 1'b1;
         sclk    <= RESET_IDLE_HI;
         early_q <= 1'b0;
         h_q     <= '0;
      end else begin
         done <= 1'b0;
         if (go) begin
            busy    <= 1'b1;
            cs_n    <= 1'b0;
            sclk    <= scheme_in.idle_hi;
            early_q <= scheme_in.early;
            h_q     <= '0;
         end else if (fin_evt) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
            done <= 1'b1;
            h_q  <= '0;
         end else if (edge_ok) begin
            sclk <= ~sclk;
            h_q  <= h_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/spi_ds_shift.sv
module spi_ds_shift #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [WORD_W-1:0] tx_in,
   input  logic              early_in,
   input  logic              early_q,
   input  logic              lead_evt,
   input  logic              trail_evt,
   input  logic              fin_evt,
   input  logic              miso,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_word
);

   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] rx_q;
   logic              launch;
   logic              capture;

   // Early launch moves the drive point to the trailing edge
   always_comb begin
      launch  = early_q ? trail_evt : lead_evt;
      capture = early_q ? lead_evt  : trail_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '0;
         rx_q    <= '0;
         mosi    <= 1'b0;
         rx_word <= '0;
      end else if (go) begin
         tx_q <= early_in ? {tx_in[WORD_W-2:0], 1'b0} : tx_in;
         mosi <= early_in & tx_in[WORD_W-1];
         rx_q <= '0;
      end else begin
         if (launch) begin
            mosi <= tx_q[WORD_W-1];
            tx_q <= {tx_q[WORD_W-2:0], 1'b0};
         end
         if (capture) rx_q <= {rx_q[WORD_W-2:0], miso};
         if (fin_evt) rx_word <= rx_q;
      end
   end

endmodule

// File: rtl/spi_dualscheme_master.sv
module spi_dualscheme_master
   import spi_ds_pkg::*;
#(
   parameter int   WORD_W        = 16,
   parameter int   DIV_W         = 8,
   parameter logic RESET_IDLE_HI = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rw_read,
   input  logic [WORD_W-1:0] tx_word,
   input  logic [1:0]        wr_scheme,
   input  logic [1:0]        rd_scheme,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rx_word,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   scheme_t sel;
   logic    go;
   logic    tick;
   logic    early_q;
   logic    lead_evt;
   logic    trail_evt;
   logic    fin_evt;

   assign sel = pick_scheme(rw_read, wr_scheme, rd_scheme);
   assign go  = start && !busy;

   spi_ds_halfgen #(.DIV_W(DIV_W)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (go),
      .run    (busy),
      .div_in (half_div),
      .tick   (tick)
   );

   spi_ds_seq #(.WORD_W(WORD_W), .RESET_IDLE_HI(RESET_IDLE_HI)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .scheme_in (sel),
      .tick      (tick),
      .busy      (busy),
      .done      (done),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .early_q   (early_q),
      .lead_evt  (lead_evt),
      .trail_evt (trail_evt),
      .fin_evt   (fin_evt)
   );

   spi_ds_shift #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .tx_in     (tx_word),
      .early_in  (sel.early),
      .early_q   (early_q),
      .lead_evt  (lead_evt),
      .trail_evt (trail_evt),
      .fin_evt   (fin_evt),
      .miso      (miso),
      .mosi      (mosi),
      .rx_word   (rx_word)
   );

endmodule

// File: rtl/spi_ds_checker.sv
module spi_ds_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic cs_n,
   input logic sclk,
   input logic mosi
);

   p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   p_cs_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> $stable(sclk));

   p_start_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !cs_n));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_idle_sclk_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(sclk));

   // R5 and R6: mid-transfer, mosi only moves together with an sclk edge
   p_mosi_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (mosi != $past(mosi))) |-> (sclk != $past(sclk)));

endmodule

bind spi_dualscheme_master spi_ds_checker u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .cs_n  (cs_n),
   .sclk  (sclk),
   .mosi  (mosi)
);

// File: tb/spi_dualscheme_master_test.sv
`timescale 1ns/1ps
module spi_dualscheme_master_test;

   localparam int W  = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          rw_read = 1'b0;
   logic [W-1:0]  tx_word = '0;
   logic [1:0]    wr_scheme = 2'b11;
   logic [1:0]    rd_scheme = 2'b10;
   logic [DW-1:0] half_div = '0;
   logic          miso = 1'b0;
   logic          busy, done, sclk, cs_n, mosi;
   logic [W-1:0]  rx_word;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   spi_dualscheme_master #(.WORD_W(W), .DIV_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .rw_read(rw_read),
      .tx_word(tx_word), .wr_scheme(wr_scheme), .rd_scheme(rd_scheme),
      .half_div(half_div), .miso(miso), .busy(busy), .done(done),
      .rx_word(rx_word), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit           m_active = 0;
   bit           m_done   = 0;
   int           m_k      = 0;
   int           m_half   = 1;
   bit           m_cpol   = 1;
   bit           m_early  = 0;
   logic [W-1:0] m_tx     = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_active = 0; m_done = 0; m_k = 0; m_cpol = 1; m_early = 0;
      end else begin
         m_done = 0;
         if (m_active) begin
            m_k++;
            if (m_k == (2*W+1)*m_half) begin
               m_active = 0;
               m_done   = 1;
            end
         end else if (start) begin
            m_active = 1;
            m_k      = 0;
            m_half   = int'(half_div) + 1;
            m_tx     = tx_word;
            m_cpol   = rw_read ? rd_scheme[1] : wr_scheme[1];
            m_early  = rw_read ? rd_scheme[0] : wr_scheme[0];
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int  e;
         bit  es, em;
         e = m_active ? m_k / m_half : 0;
         if (e > 2*W) e = 2*W;
         es = m_cpol ^ e[0];
         if (!m_active) em = mosi;
         else if (m_early) em = (e/2 < W) ? m_tx[W-1-e/2] : 1'b0;
         else em = (e == 0) ? 1'b0 : m_tx[W-1-(e-1)/2];
         chk(sclk == es, "R4 R7 R11 sclk", longint'(sclk), longint'(es));
         chk(cs_n == !m_active, "R8 cs_n", longint'(cs_n), longint'(!m_active));
         chk(busy == m_active, "R2 busy", longint'(busy), longint'(m_active));
         chk(done == m_done, "R10 done", longint'(done), longint'(m_done));
         if (m_active) chk(mosi == em, "R5 R6 R9 mosi", longint'(mosi), longint'(em));
      end
   end

   // ---------------- peripheral model ----------------
   logic [W-1:0] s_data = '0;
   logic [W-1:0] s_rx   = '0;
   bit           s_early = 0;
   int           s_e = 0;
   logic         p_cs = 1'b1, p_sclk = 1'b1;

   always @(negedge clk) begin
      if (!cs_n && p_cs) begin
         s_e  = 0;
         s_rx = '0;
         miso = s_early ? s_data[W-1] : 1'b0;
      end else if (!cs_n && (sclk != p_sclk)) begin
         s_e++;
         if (s_e % 2 == 1) begin
            if (s_early) s_rx = {s_rx[W-2:0], mosi};
            else         miso = s_data[W-1-(s_e-1)/2];
         end else begin
            if (s_early) begin
               if (s_e/2 < W) miso = s_data[W-1-s_e/2];
            end else s_rx = {s_rx[W-2:0], mosi};
         end
      end
      p_cs   = cs_n;
      p_sclk = sclk;
   end

   // ---------------- stimulus ----------------
   task automatic xfer(input bit rd, input logic [W-1:0] tx, input logic [W-1:0] sd,
                       input logic [1:0] ws, input logic [1:0] rs, input int div,
                       input bit disturb, input string req);
      int n;
      @(negedge clk);
      rw_read = rd; tx_word = tx; wr_scheme = ws; rd_scheme = rs;
      half_div = DW'(div); s_data = sd; s_early = rd ? rs[0] : ws[0];
      start = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 1) start = 1'b0;
         if (disturb && n == 10) begin
            start = 1'b1; tx_word = ~tx; wr_scheme = ~ws; rd_scheme = ~rs;
            half_div = DW'(div + 1); rw_read = ~rd;
         end
         if (disturb && n == 11) start = 1'b0;
      end while (!done);
      chk(n == (2*W+1)*(div+1) + 1, {req, " R7 length"}, longint'(n), longint'((2*W+1)*(div+1)+1));
      chk(rx_word == sd, {req, " R9 rx_word"}, longint'(rx_word), longint'(sd));
      chk(s_rx == tx, {req, " peripheral got"}, longint'(s_rx), longint'(tx));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cs_n == 1'b1 && sclk == 1'b1, "R1 cs_n/sclk", longint'({cs_n, sclk}), 64'h3);
      chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", longint'({busy, done}), 64'h0);
      chk(rx_word == '0, "R1 rx_word", longint'(rx_word), 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: write and read use different schemes automatically
      xfer(1'b0, 16'hA5C3, 16'h0000, 2'b11, 2'b10, 0, 1'b0, "R3 R6 write 11");
      xfer(1'b1, 16'h0000, 16'h3C5A, 2'b11, 2'b10, 0, 1'b0, "R3 R5 read 10");
      xfer(1'b0, 16'h8001, 16'hFFFF, 2'b11, 2'b10, 1, 1'b0, "R3 R6 write 11 div1");
      xfer(1'b1, 16'h1234, 16'h8001, 2'b11, 2'b10, 1, 1'b0, "R3 R5 read 10 div1");

      // R4: every code used as write scheme and as read scheme
      for (int s = 0; s < 4; s++) begin
         xfer(1'b0, 16'hC0DE ^ 16'(s), 16'h5A5A ^ 16'(s << 4), 2'(s), 2'b10, s % 2, 1'b0, "R4 write scheme");
         xfer(1'b1, 16'h0F0F ^ 16'(s), 16'hBEEF ^ 16'(s << 8), 2'b11, 2'(s), 2, 1'b0, "R4 read scheme");
      end

      // R11: idle-low write leaves sclk low while idle
      xfer(1'b0, 16'h6E6E, 16'h1111, 2'b00, 2'b10, 0, 1'b0, "R11 idle low");
      repeat (3) @(negedge clk);
      chk(sclk == 1'b0, "R11 idle level", longint'(sclk), 64'h0);
      xfer(1'b1, 16'h2222, 16'hF00D, 2'b00, 2'b11, 0, 1'b0, "R11 back to high");
      repeat (2) @(negedge clk);
      chk(sclk == 1'b1, "R11 idle level high", longint'(sclk), 64'h1);

      // R2 and R3: start, scheme, divider, direction changed mid-transfer are ignored
      xfer(1'b0, 16'h9C3F, 16'h4321, 2'b11, 2'b10, 0, 1'b1, "R2 R3 disturb write");
      xfer(1'b1, 16'h0001, 16'hABCD, 2'b01, 2'b00, 1, 1'b1, "R2 R3 disturb read");

      // R10: start held through the done cycle is taken at the next edge
      @(negedge clk);
      rw_read = 1'b0; tx_word = 16'h7777; wr_scheme = 2'b11; half_div = '0;
      s_data = 16'h1357; s_early = 1'b1; start = 1'b1;
      do @(negedge clk); while (!done);
      chk(s_rx == 16'h7777, "R10 first word", longint'(s_rx), 64'h7777);
      chk(busy == 1'b0, "R10 busy low in done cycle", longint'(busy), 64'h0);
      rw_read = 1'b1; rd_scheme = 2'b10; tx_word = 16'h0A0A; s_data = 16'hE1E1; s_early = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1 && cs_n == 1'b0, "R10 back-to-back accept", longint'({busy, cs_n}), 64'h2);
      do @(negedge clk); while (!done);
      chk(rx_word == 16'hE1E1, "R10 R9 second word", longint'(rx_word), 64'hE1E1);
      chk(s_rx == 16'h0A0A, "R10 second peripheral word", longint'(s_rx), 64'h0A0A);

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=below 150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule